// File: doc/BRIEF.md
# Fixed-Point Logical Execution Unit

This unit executes the bitwise logical family of a 64-bit integer core whose bits are numbered from the most significant end. It takes a 5-bit operation code, two register operands, a 16-bit unsigned immediate, a record bit and the current summary-overflow bit. It returns the result one clock later, together with an optional 4-bit condition field and a write-enable for that field. Decode, the register file and the fixed-point exception register stay outside the unit.

Three kinds of operation are supported. The eight register-register logical functions combine the two operands. The immediate forms combine the first operand with the immediate, either zero-extended or shifted up by 16 bits. Sign extension copies a byte, halfword or word of the first operand across the full width. The unit has no carry or overflow outputs, so it cannot change that state.

Top module: `logic_eu`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `res_q` is 0, `cr_q` is 0 and `cr_we_q` is 0.
- R2: Register-register codes give, with a = `src_a` and b = `src_b`: 0 a&b, 1 a|b, 2 a^b, 3 ~(a&b), 4 ~(a|b), 5 ~(a^b), 6 a&~b, 7 a|~b.
- R3: Immediate codes 8 (AND), 9 (OR) and 10 (XOR) combine `src_a` with `imm` zero-extended to XLEN bits.
- R4: Shifted-immediate codes 11 (AND), 12 (OR) and 13 (XOR) combine `src_a` with `imm` placed in result bits 31:16 (counting from the LSB), with zeros in bits 15:0 and zeros above bit 31.
- R5: Codes 14, 15 and 16 sign-extend `src_a` from bit XLEN/8-1, XLEN/4-1 and XLEN/2-1 (bits 7, 15 and 31 at XLEN=64) into every higher bit.
- R6: When `cr_we_q` is 1, `cr_q` is {LT, GT, EQ, SO}: bit 3 is set when the result is negative as a signed value, bit 2 when it is positive and non-zero, bit 1 when it is zero, and bit 0 copies `so_in`. When `cr_we_q` is 0, `cr_q` is 0.
- R7: Codes 8 and 11 always assert `cr_we_q`, whatever the value of `rec`.
- R8: Codes 9, 10, 12 and 13 never assert `cr_we_q`, and `rec` has no effect on them.
- R9: For codes 0 to 7 and 14 to 16, `cr_we_q` equals `rec`.
- R10: Codes 17 to 31 give `res_q` = 0 and `cr_we_q` = 0.
- R11: Each operation is presented for one rising edge, and its outputs appear after that edge. A new operation may be presented on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 5 | Operation code |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand |
| imm | input | 16 | Unsigned immediate |
| rec | input | 1 | Record bit for register and extend forms |
| so_in | input | 1 | Current summary-overflow bit |
| res_q | output | XLEN | Registered result |
| cr_q | output | 4 | Registered condition field {LT,GT,EQ,SO} |
| cr_we_q | output | 1 | Condition field write-enable |

## Verification
The hardest case is the condition-field gate. The write-enable depends on the code group and on the record bit together, and the wrong pairing looks like a correct result. The bench therefore sweeps all 32 codes against both values of the record bit and both values of the summary-overflow input. The operand patterns sit on the sign-extension boundaries (bits 7, 15 and 31 set or clear) and include the all-zero and sign-bit-only values, so every LT/GT/EQ outcome appears under every gating case.

// File: rtl/logic_eu.sv
module logic_eu #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [15:0]     imm,
  input  logic            rec,
  input  logic            so_in,
  output logic [XLEN-1:0] res_q,
  output logic [3:0]      cr_q,
  output logic            cr_we_q
);
  localparam int BYTE_W = XLEN / 8;
  localparam int HALF_W = XLEN / 4;
  localparam int WORD_W = XLEN / 2;

  logic [XLEN-1:0] imm_lo, imm_hi, res_d;
  logic            we_d;
  logic [3:0]      cr_d;

  assign imm_lo = {{(XLEN-16){1'b0}}, imm};
  assign imm_hi = {{(XLEN-32){1'b0}}, imm, 16'h0000};

  always_comb begin
    res_d = '0;
    we_d  = 1'b0;
    case (op)
      5'd0:  begin res_d = src_a & src_b;     we_d = rec; end
      5'd1:  begin res_d = src_a | src_b;     we_d = rec; end
      5'd2:  begin res_d = src_a ^ src_b;     we_d = rec; end
      5'd3:  begin res_d = ~(src_a & src_b);  we_d = rec; end
      5'd4:  begin res_d = ~(src_a | src_b);  we_d = rec; end
      5'd5:  begin res_d = ~(src_a ^ src_b);  we_d = rec; end
      5'd6:  begin res_d = src_a & ~src_b;    we_d = rec; end
      5'd7:  begin res_d = src_a | ~src_b;    we_d = rec; end
      5'd8:  begin res_d = src_a & imm_lo;    we_d = 1'b1; end
      5'd9:  res_d = src_a | imm_lo;
      5'd10: res_d = src_a ^ imm_lo;
      5'd11: begin res_d = src_a & imm_hi;    we_d = 1'b1; end
      5'd12: res_d = src_a | imm_hi;
      5'd13: res_d = src_a ^ imm_hi;
      5'd14: begin
        res_d = {{(XLEN-BYTE_W){src_a[BYTE_W-1]}}, src_a[BYTE_W-1:0]};
        we_d  = rec;
      end
      5'd15: begin
        res_d = {{(XLEN-HALF_W){src_a[HALF_W-1]}}, src_a[HALF_W-1:0]};
        we_d  = rec;
      end
      5'd16: begin
        res_d = {{(XLEN-WORD_W){src_a[WORD_W-1]}}, src_a[WORD_W-1:0]};
        we_d  = rec;
      end
      default: begin res_d = '0; we_d = 1'b0; end
    endcase
  end

  assign cr_d = we_d ? {res_d[XLEN-1],
                        ~res_d[XLEN-1] & (|res_d),
                        ~(|res_d),
                        so_in}
                     : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      cr_q    <= '0;
      cr_we_q <= 1'b0;
    end else begin
      res_q   <= res_d;
      cr_q    <= cr_d;
      cr_we_q <= we_d;
    end
  end
endmodule

// File: rtl/logic_eu_chk.sv
module logic_eu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      op,
  input logic [XLEN-1:0] src_a,
  input logic            rec,
  input logic            so_in,
  input logic [XLEN-1:0] res_q,
  input logic [3:0]      cr_q,
  input logic            cr_we_q
);
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 5'd16) |=> (res_q == '0 && !cr_we_q)); // R10
  AST_ANDI_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd8 || op == 5'd11) |=> cr_we_q); // R7
  AST_ORXOR_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd9 || op == 5'd10 || op == 5'd12 || op == 5'd13) |=> !cr_we_q); // R8
  AST_REC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (op <= 5'd7 || (op >= 5'd14 && op <= 5'd16)) |=> (cr_we_q == $past(rec))); // R9
  AST_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we_q |-> ($countones(cr_q[3:1]) == 1)); // R6
  AST_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we_q |-> (cr_q[1] == (res_q == '0))); // R6
  AST_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd8) |=> (cr_q[0] == $past(so_in))); // R6
  AST_CR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cr_we_q |-> (cr_q == 4'b0000)); // R6
  AST_ANDI_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd8) |=> (res_q[XLEN-1:16] == '0)); // R3
  AST_EXTB_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd14) |=> (res_q[XLEN-1] == $past(src_a[XLEN/8-1]))); // R5
endmodule

bind logic_eu logic_eu_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .src_a(src_a), .rec(rec),
  .so_in(so_in), .res_q(res_q), .cr_q(cr_q), .cr_we_q(cr_we_q)
);

// File: tb/logic_eu_tb.sv
module logic_eu_tb;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      op = '0;
  logic [XLEN-1:0] src_a = '0, src_b = '0;
  logic [15:0]     imm = '0;
  logic            rec = 1'b0, so_in = 1'b0;
  logic [XLEN-1:0] res_q;
  logic [3:0]      cr_q;
  logic            cr_we_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  logic_eu #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .src_a(src_a), .src_b(src_b),
    .imm(imm), .rec(rec), .so_in(so_in), .res_q(res_q), .cr_q(cr_q),
    .cr_we_q(cr_we_q)
  );

  function automatic string req_of(input int c);
    if (c <= 7) return "R2";
    if (c <= 10) return "R3";
    if (c <= 13) return "R4";
    if (c <= 16) return "R5";
    return "R10";
  endfunction

  function automatic logic [XLEN-1:0] ref_res(input int c, input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b, input logic [15:0] i);
    logic [XLEN-1:0] zi, si;
    logic signed [XLEN-1:0] t;
    zi = XLEN'(i);
    si = XLEN'(i) * 65536;
    case (c)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return ~a | ~b;
      4: return ~a & ~b;
      5: return (a & b) | (~a & ~b);
      6: return a & (b ^ '1);
      7: return ~(~a & b);
      8: return a & zi;
      9: return a | zi;
      10: return a ^ zi;
      11: return a & si;
      12: return a | si;
      13: return a ^ si;
      14: begin t = $signed(a[7:0]); return t; end
      15: begin t = $signed(a[15:0]); return t; end
      16: begin t = $signed(a[31:0]); return t; end
      default: return '0;
    endcase
  endfunction

  function automatic logic ref_we(input int c, input logic r);
    if (c == 8 || c == 11) return 1'b1;
    if (c >= 9 && c <= 13) return 1'b0;
    if (c <= 16) return r;
    return 1'b0;
  endfunction

  task automatic check(input string rq, input logic [XLEN-1:0] er, input logic ew,
                       input logic [3:0] ec);
    checks++;
    if (res_q !== er || cr_we_q !== ew || cr_q !== ec) begin
      errors++;
      $display("FAIL %s op=%0d: res=%h we=%b cr=%b expected res=%h we=%b cr=%b",
               rq, op, res_q, cr_we_q, cr_q, er, ew, ec);
    end
  endtask

  function automatic logic [3:0] ref_cr(input logic ew, input logic [XLEN-1:0] r, input logic s);
    logic signed [XLEN-1:0] v;
    v = r;
    if (!ew) return 4'b0000;
    return {v < 0, v > 0, v == 0, s};
  endfunction

  logic [XLEN-1:0] pats [8];
  logic [15:0]     imms [3];

  initial begin
    pats[0] = 64'h0;
    pats[1] = '1;
    pats[2] = 64'h8000_0000_0000_0000;
    pats[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    pats[4] = 64'h0123_4567_89AB_CDEF;
    pats[5] = 64'hFEDC_BA98_7654_3210;
    pats[6] = 64'h0000_0000_8000_8080;
    pats[7] = 64'hFFFF_FFFF_7FFF_7F7F;
    imms[0] = 16'hFFFF;
    imms[1] = 16'h8001;
    imms[2] = 16'h0000;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0, 1'b0, 4'b0000);

    for (int c = 0; c < 32; c++) begin
      for (int p = 0; p < 8; p++) begin
        for (int rs = 0; rs < 4; rs++) begin
          logic [XLEN-1:0] er;
          logic ew;
          string rq;
          op = 5'(c);
          src_a = pats[p];
          src_b = pats[(p + 3 + c) % 8];
          imm = imms[(p + rs) % 3];
          rec = rs[0];
          so_in = rs[1];
          er = ref_res(c, src_a, src_b, imm);
          ew = ref_we(c, rec);
          @(negedge clk);
          rq = req_of(c);
          if (c == 8 || c == 11) rq = {rq, "/R7"};
          else if (c >= 9 && c <= 13) rq = {rq, "/R8"};
          else if (c <= 16) rq = {rq, "/R9"};
          check({rq, "/R6"}, er, ew, ref_cr(ew, er, so_in));
        end
      end
    end

    // R11: back-to-back operations, each seen one edge after it is presented
    op = 5'd0; src_a = pats[4]; src_b = pats[5]; rec = 1'b1; so_in = 1'b0;
    @(negedge clk);
    check("R11", pats[4] & pats[5], 1'b1, ref_cr(1'b1, pats[4] & pats[5], 1'b0));
    op = 5'd14; src_a = pats[6]; rec = 1'b0;
    @(negedge clk);
    check("R11", 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 4'b0000);
    op = 5'd20;
    @(negedge clk);
    check("R11", '0, 1'b0, 4'b0000);

    // R1: reset again clears the outputs
    op = 5'd1; src_a = '1; rec = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", '0, 1'b0, 4'b0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule